// File: doc/BRIEF.md
# Bin-Reshaping Fractional Gap Estimator

This block sits in the background-calibration path of a pipelined converter. It watches the raw output codes of one stage's decision boundary and estimates how wide the missing-code (or duplicate-code) region is. Each incoming code comes with its stage decision bit. The block first drops `cfg_drop` noisy low bits from each code, which merges 2^`cfg_drop` fine bins into one coarse bin. On the low side (decision 0) it looks for the largest coarse code. On the high side (decision 1) it looks for the smallest coarse code.

These two coarse extremes locate the gap edges for the next block of samples. During each block the block counts two bins on each side: the innermost coarse bin next to the gap, and the bin just outside it. A serial shift-and-subtract divider turns each pair of counts into a fraction. The fraction is the width of the innermost bin after it is reshaped to its neighbour's height with its area kept. The two fractions move each edge from coarse to fine resolution.

The result is a signed gap in fine LSBs with `F` fraction bits. It is issued with a one-cycle done pulse once per block of `cfg_block_len` accepted samples. Applying the correction to the samples is done downstream.

Top module: `bin_reshape_gap_est`

## Requirements
- R1: While reset is held and after it is released, `est_done` is 0, and `est_gap`, `est_flag_lo` and `est_flag_hi` are all 0 until the first estimate.
- R2: The coarse code of a sample is `in_code >> cfg_drop`. All extreme searches and bin matches use the coarse code.
- R3: A block consists of `cfg_block_len` accepted samples, where `cfg_block_len` is at least F+2. All bin counters and extreme searches start from zero with each new block.
- R4: At the end of a block, the largest coarse code with decision 0 becomes the low location. The smallest coarse code with decision 1 becomes the high location. A side that received no samples in the block keeps its old location. No estimate is issued for a block until both locations have been set at least once before that block started.
- R5: During a block, inner_lo counts the decision-0 samples whose coarse code equals the low location, and nb_lo counts those whose coarse code equals the low location minus 1. inner_hi counts the decision-1 samples whose coarse code equals the high location, and nb_hi counts those whose coarse code equals the high location plus 1.
- R6: Each edge fraction is floor(inner·2^F / nb). It is clamped to 2^F when inner ≥ nb. When nb = 0 the fraction is 0, and that side's flag (`est_flag_lo` or `est_flag_hi`) is 1 for that estimate.
- R7: `est_gap` = ((hi_loc + 1 − lo_loc)·2^F − frac_lo − frac_hi)·2^cfg_drop. It is a two's-complement value in fine LSBs with F fraction bits, so a duplicate-code overlap gives a negative value.
- R8: `est_done` is a one-cycle pulse. It is high in the (F+1)-th clock cycle after the clock edge that accepts the block's last sample. `est_gap` and the flags hold their values until the next pulse.
- R9: A cycle with `in_valid` low changes no count, no location and no block position, whatever `in_dec` and `in_code` carry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Sample present this cycle |
| in_dec | input | 1 | Stage decision bit of the sample (0 low side, 1 high side) |
| in_code | input | W | Raw fine-resolution output code |
| cfg_drop | input | $clog2(W) | Number of low bits dropped to form the coarse code |
| cfg_block_len | input | LEN_W | Samples per estimation block |
| est_done | output | 1 | New estimate pulse |
| est_gap | output | W+F+2 | Signed gap estimate, fine LSBs with F fraction bits |
| est_flag_lo | output | 1 | Low-side neighbour bin was empty for this estimate |
| est_flag_hi | output | 1 | High-side neighbour bin was empty for this estimate |

## Verification
The bench sweeps every drop width from 0 to 3 over shifted gap positions. The main function is tried with five patterns:
- Clean ramps on both sides open a true missing-code gap, which checks the positive gap and the interpolated fractions.
- Ramps with codes that spill into the gap make the inner bin fuller than its neighbour, which checks the clamp.
- A single repeated code per side leaves the neighbour bins empty, which checks the zero-divisor flag.
- Overlapping sides check the negative (duplicate-code) result.
- One-sided blocks show that the empty side keeps its location.

Idle cycles that carry an inner-bin code show that invalid cycles are ignored. The first block after reset shows that the done pulse is held back until both locations exist.

// File: rtl/gap_est_pkg.sv
// Package gap_est_pkg
// Shared types of the bin-reshaping gap estimator. It holds only the
// selector that tells a bin tracker which side of the gap it watches.
package gap_est_pkg;
    typedef enum logic {
        SIDE_LOW  = 1'b0,
        SIDE_HIGH = 1'b1
    } side_e;
endpackage

// File: rtl/edge_bin_tracker.sv
// Module edge_bin_tracker
// Watches one side of the decision-boundary gap. Over a block it finds
// the extreme coarse code closest to the gap: the maximum on the low side,
// the minimum on the high side. It counts the samples that hit the current
// inner bin and the samples that hit its outer neighbour. When the block
// ends, the extreme becomes the location used by the next block.
// Assumes: hit is already qualified by valid and by the decision bit.
module edge_bin_tracker
    import gap_est_pkg::*;
#(
    parameter int    W    = 8,
    parameter int    CW   = 10,
    parameter side_e SIDE = SIDE_LOW
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          hit,
    input  logic [W-1:0]  coarse,
    input  logic          blk_end,
    output logic [W-1:0]  loc,
    output logic          loc_ok,
    output logic [CW-1:0] cnt_in_nxt,
    output logic [CW-1:0] cnt_nb_nxt
);
    logic [W-1:0]  ext_cur, ext_nxt;
    logic          seen_cur, seen_nxt;
    logic [CW-1:0] cnt_in, cnt_nb;
    logic          better, in_hit, nb_hit;
    logic [W:0]    coarse_x, loc_x;

    // Next-state of the extreme search and of the two bin counters
    always_comb begin
        coarse_x   = {1'b0, coarse};
        loc_x      = {1'b0, loc};
        better     = (SIDE == SIDE_HIGH) ? (coarse < ext_cur) : (coarse > ext_cur);
        seen_nxt   = seen_cur | hit;
        ext_nxt    = (hit && (!seen_cur || better)) ? coarse : ext_cur;
        in_hit     = hit && (coarse == loc);
        if (SIDE == SIDE_HIGH) begin
            nb_hit = hit && (coarse_x == loc_x + (W+1)'(1));
        end else begin
            nb_hit = hit && (coarse_x + (W+1)'(1) == loc_x);
        end
        cnt_in_nxt = cnt_in + CW'(in_hit);
        cnt_nb_nxt = cnt_nb + CW'(nb_hit);
    end

    // Block-scoped accumulation; location hand-over at block end
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_in   <= '0;
            cnt_nb   <= '0;
            seen_cur <= 1'b0;
            ext_cur  <= '0;
            loc      <= (SIDE == SIDE_HIGH) ? '1 : '0;
            loc_ok   <= 1'b0;
        end else if (blk_end) begin
            cnt_in   <= '0;
            cnt_nb   <= '0;
            seen_cur <= 1'b0;
            ext_cur  <= '0;
            if (seen_nxt) begin
                loc    <= ext_nxt;
                loc_ok <= 1'b1;
            end
        end else begin
            cnt_in   <= cnt_in_nxt;
            cnt_nb   <= cnt_nb_nxt;
            seen_cur <= seen_nxt;
            ext_cur  <= ext_nxt;
        end
    end

    // R3: a block starts with empty counters
    assert_clear_R3: assert property (@(posedge clk) disable iff (!rst_n)
        blk_end |=> (cnt_in == '0 && cnt_nb == '0));

    // R4: once a location exists it is never lost
    assert_loc_sticky_R4: assert property (@(posedge clk) disable iff (!rst_n)
        loc_ok |=> loc_ok);
endmodule

// File: rtl/ratio_serial_div.sv
// Module ratio_serial_div
// Slow restoring divider for the edge fraction floor(num*2^F/den). It
// takes F steps after start and returns frac with F fraction bits. The
// result is clamped to 1.0 when num >= den and forced to 0 (with
// zero_den set) when den is 0. Assumes start never arrives while busy.
module ratio_serial_div #(
    parameter int CW = 10,
    parameter int F  = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic [CW-1:0] num,
    input  logic [CW-1:0] den,
    output logic          busy,
    output logic          fin,
    output logic [F:0]    frac,
    output logic          zero_den
);
    localparam int KW = $clog2(F + 1);

    logic [CW:0]   rem, rem2;
    logic [CW-1:0] den_r;
    logic [F:0]    quo;
    logic [KW-1:0] steps;
    logic          sat;

    // One shift-and-subtract step of the long division
    always_comb begin
        rem2 = {rem[CW-1:0], 1'b0};
    end

    // Load, iterate F times, then pulse fin
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rem      <= '0;
            den_r    <= '0;
            quo      <= '0;
            steps    <= '0;
            busy     <= 1'b0;
            fin      <= 1'b0;
            sat      <= 1'b0;
            zero_den <= 1'b0;
        end else if (start) begin
            rem      <= {1'b0, num};
            den_r    <= den;
            quo      <= '0;
            steps    <= KW'(F);
            busy     <= 1'b1;
            fin      <= 1'b0;
            sat      <= (num >= den);
            zero_den <= (den == '0);
        end else if (busy) begin
            if (rem2 >= {1'b0, den_r}) begin
                rem <= rem2 - {1'b0, den_r};
                quo <= {quo[F-1:0], 1'b1};
            end else begin
                rem <= rem2;
                quo <= {quo[F-1:0], 1'b0};
            end
            steps <= steps - KW'(1);
            if (steps == KW'(1)) begin
                busy <= 1'b0;
                fin  <= 1'b1;
            end
        end else begin
            fin <= 1'b0;
        end
    end

    // Result selection: empty divisor, clamp, or quotient
    always_comb begin
        if (zero_den)  frac = '0;
        else if (sat)  frac = (F+1)'(1) << F;
        else           frac = quo;
    end

    // R6: a fraction never exceeds one coarse bin
    assert_frac_bound_R6: assert property (@(posedge clk) disable iff (!rst_n)
        fin |-> (frac <= ((F+1)'(1) << F)));

    // R3: blocks are long enough that the divider is idle at block end
    assert_no_restart_R3: assert property (@(posedge clk) disable iff (!rst_n)
        start |-> !busy);
endmodule

// File: rtl/bin_reshape_gap_est.sv
// Module bin_reshape_gap_est
// Top of the gap estimator. It coarsens each code by cfg_drop bits and
// splits samples by decision bit into two edge_bin_trackers. It frames
// blocks of cfg_block_len accepted samples and starts one serial divider
// per edge at block end. When both dividers finish, it combines the
// locations used during the block with the two fractions into a signed
// fine gap. Assumes cfg_drop and cfg_block_len are stable and that
// cfg_block_len >= F+2.
module bin_reshape_gap_est
    import gap_est_pkg::*;
#(
    parameter int W     = 8,
    parameter int F     = 4,
    parameter int LEN_W = 10
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 in_valid,
    input  logic                 in_dec,
    input  logic [W-1:0]         in_code,
    input  logic [$clog2(W)-1:0] cfg_drop,
    input  logic [LEN_W-1:0]     cfg_block_len,
    output logic                 est_done,
    output logic [W+F+1:0]       est_gap,
    output logic                 est_flag_lo,
    output logic                 est_flag_hi
);
    localparam int DW = $clog2(W);
    localparam int GW = W + F + 2;
    localparam int CW = LEN_W;

    logic [W-1:0]     coarse;
    logic [LEN_W-1:0] bcnt;
    logic             blk_end;
    logic [1:0]       side_hit;
    logic [W-1:0]     loc      [2];
    logic             loc_ok   [2];
    logic [CW-1:0]    c_in     [2];
    logic [CW-1:0]    c_nb     [2];
    logic             d_busy   [2];
    logic             d_fin    [2];
    logic [F:0]       d_frac   [2];
    logic             d_zero   [2];
    logic [W-1:0]     use_lo, use_hi;
    logic             warm_r;
    logic [DW-1:0]    drop_r;
    logic signed [GW-1:0] span_s, fx_s, gap_s;

    // Coarse code, side split and end-of-block detection
    always_comb begin
        coarse      = in_code >> cfg_drop;
        side_hit[0] = in_valid & ~in_dec;
        side_hit[1] = in_valid &  in_dec;
        blk_end     = in_valid && (bcnt == cfg_block_len - LEN_W'(1));
    end

    // Block position counter over accepted samples
    always_ff @(posedge clk) begin
        if (!rst_n)        bcnt <= '0;
        else if (blk_end)  bcnt <= '0;
        else if (in_valid) bcnt <= bcnt + LEN_W'(1);
    end

    for (genvar s = 0; s < 2; s++) begin : g_edge
        edge_bin_tracker #(
            .W   (W),
            .CW  (CW),
            .SIDE((s == 1) ? SIDE_HIGH : SIDE_LOW)
        ) u_trk (
            .clk       (clk),
            .rst_n     (rst_n),
            .hit       (side_hit[s]),
            .coarse    (coarse),
            .blk_end   (blk_end),
            .loc       (loc[s]),
            .loc_ok    (loc_ok[s]),
            .cnt_in_nxt(c_in[s]),
            .cnt_nb_nxt(c_nb[s])
        );

        ratio_serial_div #(
            .CW(CW),
            .F (F)
        ) u_div (
            .clk     (clk),
            .rst_n   (rst_n),
            .start   (blk_end),
            .num     (c_in[s]),
            .den     (c_nb[s]),
            .busy    (d_busy[s]),
            .fin     (d_fin[s]),
            .frac    (d_frac[s]),
            .zero_den(d_zero[s])
        );
    end

    // Freeze the locations and scale that this block counted against
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            use_lo <= '0;
            use_hi <= '0;
            warm_r <= 1'b0;
            drop_r <= '0;
        end else if (blk_end) begin
            use_lo <= loc[0];
            use_hi <= loc[1];
            warm_r <= loc_ok[0] & loc_ok[1];
            drop_r <= cfg_drop;
        end
    end

    // Fine gap from coarse edges and interpolated fractions
    always_comb begin
        span_s = $signed({{(GW-W){1'b0}}, use_hi}) + GW'(1)
               - $signed({{(GW-W){1'b0}}, use_lo});
        fx_s   = (span_s <<< F)
               - $signed({{(GW-F-1){1'b0}}, d_frac[0]})
               - $signed({{(GW-F-1){1'b0}}, d_frac[1]});
        gap_s  = fx_s <<< drop_r;
    end

    // Publish the estimate with a one-cycle done pulse
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            est_done    <= 1'b0;
            est_gap     <= '0;
            est_flag_lo <= 1'b0;
            est_flag_hi <= 1'b0;
        end else begin
            est_done <= d_fin[0] & warm_r;
            if (d_fin[0] && warm_r) begin
                est_gap     <= gap_s;
                est_flag_lo <= d_zero[0];
                est_flag_hi <= d_zero[1];
            end
        end
    end

    // R8: the done output is a single-cycle pulse
    assert_done_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
        est_done |=> !est_done);

    // R8: a done pulse follows a finished division
    assert_done_after_div_R8: assert property (@(posedge clk) disable iff (!rst_n)
        est_done |-> $past(d_fin[1]));

    // R8: both edge dividers run in lockstep
    assert_div_lockstep_R8: assert property (@(posedge clk) disable iff (!rst_n)
        d_busy[0] == d_busy[1]);

    // R9: an idle cycle leaves the block position unchanged
    assert_idle_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> $stable(bcnt));
endmodule

// File: tb/sim_bin_reshape_gap_est.sv
module sim_bin_reshape_gap_est;
    localparam int W = 8;
    localparam int F = 4;
    localparam int LEN_W = 10;
    localparam int N = 32;
    localparam int GW = W + F + 2;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             in_valid = 1'b0;
    logic             in_dec = 1'b0;
    logic [W-1:0]     in_code = '0;
    logic [2:0]       cfg_drop = '0;
    logic [LEN_W-1:0] cfg_block_len = LEN_W'(N);
    logic             est_done;
    logic [GW-1:0]    est_gap;
    logic             est_flag_lo, est_flag_hi;

    int n_chk = 0;
    int n_bad = 0;
    bit finished = 0;

    // bench model state
    int  m_lo = 0, m_hi = 255;
    bit  m_ok_lo = 0, m_ok_hi = 0;
    int  s_dec [N];
    int  s_code [N];

    always #5 clk = ~clk;

    bin_reshape_gap_est #(.W(W), .F(F), .LEN_W(LEN_W)) u0 (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_dec(in_dec),
        .in_code(in_code), .cfg_drop(cfg_drop), .cfg_block_len(cfg_block_len),
        .est_done(est_done), .est_gap(est_gap),
        .est_flag_lo(est_flag_lo), .est_flag_hi(est_flag_hi)
    );

    task automatic check(input string req, input int got, input int exp);
        n_chk++;
        if (got != exp) begin
            n_bad++;
            $display("FAIL %s got %0d expected %0d", req, got, exp);
        end
    endtask

    function automatic int frac_of(input int inner, input int nb);
        if (nb == 0) return 0;
        if (inner >= nb) return 1 << F;
        return (inner * (1 << F)) / nb;
    endfunction

    // pattern: 0 ramp, 1 ramp with spill into gap, 2 low side only, 3 single code
    task automatic build(input int pat, input int a, input int b, input int span);
        for (int i = 0; i < N; i++) begin
            int j = i >> 1;
            s_dec[i] = (pat == 2) ? 0 : (i & 1);
            if (pat == 2) j = i;
            if (s_dec[i] == 0) s_code[i] = a - (j % span);
            else               s_code[i] = b + (j % span);
            if (pat == 1 && (j % 4) == 3)
                s_code[i] = (s_dec[i] == 0) ? a + 2 : b - 2;
        end
    endtask

    task automatic run_block(input int drop);
        int in0 = 0, nb0 = 0, in1 = 0, nb1 = 0;
        int mx = -1, mn = 1 << 20;
        bit exp_done;
        int f0, f1, exp_gap, done_at, g_got, fl_lo, fl_hi;
        cfg_drop = 3'(drop);
        for (int i = 0; i < N; i++) begin
            int c = s_code[i] >> drop;
            if (s_dec[i] == 0) begin
                if (c == m_lo) in0++;
                if (c + 1 == m_lo) nb0++;
                if (c > mx) mx = c;
            end else begin
                if (c == m_hi) in1++;
                if (c == m_hi + 1) nb1++;
                if (c < mn) mn = c;
            end
        end
        exp_done = m_ok_lo && m_ok_hi;
        f0 = frac_of(in0, nb0);
        f1 = frac_of(in1, nb1);
        exp_gap = ((m_hi + 1 - m_lo) * (1 << F) - f0 - f1) * (1 << drop);
        // drive, with idle cycles carrying an inner-bin code (R9)
        for (int i = 0; i < N; i++) begin
            if (i % 5 == 4) begin
                in_valid = 1'b0; in_dec = 1'b0; in_code = W'(m_lo << drop);
                @(negedge clk);
            end
            in_valid = 1'b1; in_dec = s_dec[i][0]; in_code = W'(s_code[i]);
            @(negedge clk);
        end
        in_valid = 1'b0;
        done_at = 0; g_got = 0; fl_lo = 0; fl_hi = 0;
        for (int n = 1; n <= F + 2; n++) begin
            @(posedge clk);
            @(negedge clk);
            if (est_done) begin
                if (done_at == 0) begin
                    done_at = n;
                    g_got = int'($signed(est_gap));
                    fl_lo = int'(est_flag_lo);
                    fl_hi = int'(est_flag_hi);
                end else done_at = -1;
            end
        end
        if (exp_done) begin
            check("R8 done latency", done_at, F + 1);
            check("R7 gap", g_got, exp_gap);
            check("R6 flag_lo", fl_lo, int'(nb0 == 0));
            check("R6 flag_hi", fl_hi, int'(nb1 == 0));
        end else begin
            check("R4 no done before locations", done_at, 0);
        end
        if (mx >= 0) begin m_lo = mx; m_ok_lo = 1; end
        if (mn < (1 << 20)) begin m_hi = mn; m_ok_hi = 1; end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check("R1 done in reset", int'(est_done), 0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 gap after reset", int'(est_gap), 0);
        check("R1 flags after reset", int'(est_flag_lo) + int'(est_flag_hi), 0);
        // first block: no location yet (R4)
        build(0, 118, 137, 10);
        run_block(0);
        // one-sided block keeps the high location (R4)
        build(2, 118, 137, 10);
        run_block(0);
        for (int d = 0; d < 4; d++) begin
            for (int off = 0; off < 4; off++) begin
                build(0, 118 + off, 137 - off, 10); run_block(d);  // R2 R5 R7
                build(0, 118 + off, 137 - off, 10); run_block(d);
                build(1, 118 + off, 137 - off, 10); run_block(d);  // R6 clamp
                build(3, 120 + off, 134, 1);        run_block(d);  // R6 empty neighbour
                build(0, 131 + off, 124, 9);        run_block(d);  // R7 negative
                build(0, 131 + off, 124, 9);        run_block(d);
                build(2, 119, 130, 7);              run_block(d);  // R4 keep location
            end
        end
        finished = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog expired");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end
endmodule